// File: doc/BRIEF.md
# Immediate Literal Function Unit

This function unit puts constants onto a transport-triggered strobe bus. A move instruction carries an 8-bit source socket field and an 8-bit destination socket field. When the source field names one of the unit's two load sockets, the unit does not treat the destination field as an address. It stores that field as an 8-bit literal into the low or high half of a 16-bit immediate register. It then ends the bus cycle by pulsing its acknowledge output, without ever raising a data strobe. No destination unit takes part in a load.

A third socket works as an ordinary source. Moving from it drives the whole immediate register onto the data bus and raises the data strobe. The unit releases the bus when the receiving unit's acknowledge rises. A constant such as 0x0B0E therefore takes three moves: a low-byte load of 0x0E, a high-byte load of 0x0B, and a move from the read socket to any sink. The fourth socket is reserved and stays silent, so a master that selects it sees a missing strobe and treats it as a source bus error.

The design is synchronous. Strobes are sampled on the clock, and only the sampled rising edge of the address strobe starts an action. The base socket is a parameter and must be a multiple of four.

Top module: `imm_literal_unit`

## Requirements
- R1: After reset the immediate register holds 0x0000, and `dack_out`, `data_stb`, `data_oe` and `data_out` are all low.
- R2: A sampled rising edge of `addr_stb` with `src_sel` = BASE+0 copies `dst_sel` into register bits 7:0 and leaves bits 15:8 unchanged.
- R3: A sampled rising edge of `addr_stb` with `src_sel` = BASE+1 copies `dst_sel` into register bits 15:8 and leaves bits 7:0 unchanged.
- R4: On a load, `dack_out` is high for exactly one clock cycle. The pulse starts in the cycle right after the clock edge that samples the address strobe rise. During a load `data_stb` and `data_oe` stay low.
- R5: A sampled rising edge of `addr_stb` with `src_sel` = BASE+2 raises `data_oe` in the next cycle, with `data_out` equal to the register. `data_stb` follows one cycle after that and stays high while the unit drives the bus.
- R6: While the unit drives the bus, a sampled rising edge of `dack_in` drops `data_oe` and `data_stb` in the next cycle, and `data_out` returns to 0.
- R7: A move whose source is BASE+3, or a socket outside BASE..BASE+3, produces no `dack_out`, no `data_stb` and no bus drive, and leaves the register unchanged.
- R8: Only the rise of `addr_stb` triggers an action. Holding `addr_stb` high produces no further acknowledge pulses and no further loads.
- R9: A low load of 0x0E, then a high load of 0x0B, then a read from BASE+2 puts 0x0B0E on `data_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 8 | Source socket field of the current move |
| dst_sel | input | 8 | Destination socket field; used as the literal on loads |
| addr_stb | input | 1 | Address strobe; its rising edge starts a move |
| dack_in | input | 1 | Acknowledge from the destination unit during a read |
| data_out | output | 16 | Immediate value while driving, zero otherwise |
| data_oe | output | 1 | High while the unit drives the data bus |
| data_stb | output | 1 | Data strobe for reads from BASE+2 |
| dack_out | output | 1 | One-cycle acknowledge that ends a load cycle |

## Verification
Directed sequences come first: the 0x0E/0x0B load pair, back-to-back loads of the same half, and a strobe held high for several cycles. These separate a correct per-half merge from a whole-word overwrite, and a rise-triggered action from a level-triggered one. Seeded random mixes of low loads, high loads, reads, reserved-socket selects and out-of-range sockets, each with a random literal in the destination field, show whether the halves stay independent and whether silent sockets disturb the register. Reads wait a random number of cycles before the acknowledge arrives. This checks that the data strobe holds and that the bus is released only on the acknowledge rise.

// File: rtl/imm_unit_pkg.sv
package imm_unit_pkg;
  localparam int ADDR_W    = 8;
  localparam int LIT_W     = ADDR_W;
  localparam int DATA_W    = 2 * LIT_W;
  localparam int SOCK_LOG2 = 2;

  typedef enum logic [2:0] {
    SK_NONE,
    SK_LO,
    SK_HI,
    SK_READ,
    SK_RSVD
  } sock_e;

  // Classify a source field against the unit's four-socket window.
  function automatic sock_e sock_of(input logic [ADDR_W-1:0] base,
                                    input logic [ADDR_W-1:0] src);
    logic [SOCK_LOG2-1:0] off;
    off = src[SOCK_LOG2-1:0];
    if (src[ADDR_W-1:SOCK_LOG2] != base[ADDR_W-1:SOCK_LOG2]) return SK_NONE;
    case (off)
      2'd0:    return SK_LO;
      2'd1:    return SK_HI;
      2'd2:    return SK_READ;
      default: return SK_RSVD;
    endcase
  endfunction

  // Replace one half of the immediate word with a literal.
  function automatic logic [DATA_W-1:0] half_merge(input logic [DATA_W-1:0] old,
                                                   input logic [LIT_W-1:0]  lit,
                                                   input logic              upper);
    if (upper) return {lit, old[LIT_W-1:0]};
    return {old[DATA_W-1:LIT_W], lit};
  endfunction
endpackage

// File: rtl/imm_sock_decode.sv
module imm_sock_decode
  import imm_unit_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 8'h08
) (
  input  logic [ADDR_W-1:0] src_sel,
  output sock_e             sel
);
  always_comb sel = sock_of(BASE, src_sel);

  initial begin
    base_aligned_chk: assert (BASE[SOCK_LOG2-1:0] == '0)
      else $error("base socket not aligned to the window");
  end
endmodule

// File: rtl/imm_value_reg.sv
module imm_value_reg
  import imm_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [LIT_W-1:0]  lit,
  output logic [DATA_W-1:0] imm
);
  always_ff @(posedge clk) begin
    if (!rst_n)     imm <= '0;
    else if (ld_lo) imm <= half_merge(imm, lit, 1'b0);
    else if (ld_hi) imm <= half_merge(imm, lit, 1'b1);
  end

  // R2
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> imm[DATA_W-1:LIT_W] == $past(imm[DATA_W-1:LIT_W]));
  // R2
  lo_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> imm[LIT_W-1:0] == $past(lit));
  // R3
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !ld_lo) |=> imm[LIT_W-1:0] == $past(imm[LIT_W-1:0]));
  // R3
  hi_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !ld_lo) |=> imm[DATA_W-1:LIT_W] == $past(lit));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_lo && !ld_hi) |=> $stable(imm));
endmodule

// File: rtl/imm_strobe_seq.sv
module imm_strobe_seq
  import imm_unit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  addr_stb,
  input  logic  dack_in,
  input  sock_e sel,
  output logic  ld_lo,
  output logic  ld_hi,
  output logic  ack,
  output logic  drive,
  output logic  stb
);
  logic astb_q, dackin_q;
  logic astb_rise, dack_rise, rd_go, release_evt;

  always_comb begin
    astb_rise   = addr_stb && !astb_q;
    dack_rise   = dack_in && !dackin_q;
    ld_lo       = astb_rise && (sel == SK_LO);
    ld_hi       = astb_rise && (sel == SK_HI);
    rd_go       = astb_rise && (sel == SK_READ);
    release_evt = drive && dack_rise && !rd_go;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      astb_q   <= 1'b0;
      dackin_q <= 1'b0;
      ack      <= 1'b0;
      drive    <= 1'b0;
      stb      <= 1'b0;
    end else begin
      astb_q   <= addr_stb;
      dackin_q <= dack_in;
      ack      <= ld_lo || ld_hi;
      if (rd_go)            drive <= 1'b1;
      else if (release_evt) drive <= 1'b0;
      if (release_evt)      stb <= 1'b0;
      else if (drive)       stb <= 1'b1;
    end
  end

  // R4
  ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R4
  ack_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo || ld_hi) |=> ack);
  // R4
  no_stb_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && (stb || drive)));
  // R5
  stb_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> drive);
  // R5
  read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> drive && !stb);
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !drive && !stb);
  // R7
  silent_sock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (astb_rise && (sel == SK_RSVD || sel == SK_NONE)) |=> !ack);
  // R8
  level_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && astb_q) |=> !ack);
endmodule

// File: rtl/imm_literal_unit.sv
module imm_literal_unit
  import imm_unit_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] src_sel,
  input  logic [ADDR_W-1:0] dst_sel,
  input  logic              addr_stb,
  input  logic              dack_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              data_stb,
  output logic              dack_out
);
  sock_e             sel;
  logic              ld_lo, ld_hi, drive;
  logic [DATA_W-1:0] imm;

  imm_sock_decode #(.BASE(BASE)) u_dec (
    .src_sel (src_sel),
    .sel     (sel)
  );

  imm_strobe_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_stb (addr_stb),
    .dack_in  (dack_in),
    .sel      (sel),
    .ld_lo    (ld_lo),
    .ld_hi    (ld_hi),
    .ack      (dack_out),
    .drive    (drive),
    .stb      (data_stb)
  );

  imm_value_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .lit   (dst_sel),
    .imm   (imm)
  );

  always_comb begin
    data_oe  = drive;
    data_out = drive ? imm : '0;
  end

  // R6
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == '0);
endmodule

// File: tb/imm_literal_unit_test.sv
`timescale 1ns/1ps
module imm_literal_unit_test;
  localparam logic [7:0] BASE = 8'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_sel = '0, dst_sel = '0;
  logic        addr_stb = 1'b0, dack_in = 1'b0;
  logic [15:0] data_out;
  logic        data_oe, data_stb, dack_out;

  int errors = 0;
  int checks = 0;
  logic [15:0] model = '0;

  always #10 clk = ~clk;

  imm_literal_unit #(.BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dst_sel(dst_sel),
    .addr_stb(addr_stb), .dack_in(dack_in), .data_out(data_out),
    .data_oe(data_oe), .data_stb(data_stb), .dack_out(dack_out)
  );

  function automatic logic [15:0] put_half(input logic [15:0] w, input logic [7:0] b,
                                           input bit top);
    logic [15:0] r;
    r = w;
    if (top) r[15:8] = b; else r[7:0] = b;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk(!dack_out, req, {15'd0, dack_out}, 16'd0);
    chk(!data_oe && !data_stb, req, {14'd0, data_oe, data_stb}, 16'd0);
  endtask

  task automatic do_load(input bit top, input logic [7:0] lit, input int hold);
    @(negedge clk);
    src_sel = BASE + (top ? 8'd1 : 8'd0); dst_sel = lit; addr_stb = 1'b1;
    @(negedge clk);
    chk(dack_out, "R4 ack", {15'd0, dack_out}, 16'd1);
    chk(!data_oe && !data_stb, "R4 no strobe", {14'd0, data_oe, data_stb}, 16'd0);
    model = put_half(model, lit, top);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(!dack_out, "R8 held strobe", {15'd0, dack_out}, 16'd0);
      dst_sel = ~lit;
    end
    @(negedge clk);
    chk(!dack_out, "R4 one cycle", {15'd0, dack_out}, 16'd0);
    addr_stb = 1'b0;
  endtask

  task automatic do_read(input string req, input int wait_cyc);
    @(negedge clk);
    src_sel = BASE + 8'd2; dst_sel = 8'($urandom); addr_stb = 1'b1;
    @(negedge clk);
    chk(data_oe && !data_stb, "R5 drive first", {14'd0, data_oe, data_stb}, 16'd2);
    chk(data_out == model, req, data_out, model);
    @(negedge clk);
    chk(data_stb, "R5 strobe", {15'd0, data_stb}, 16'd1);
    for (int i = 0; i < wait_cyc; i++) begin
      @(negedge clk);
      chk(data_stb && data_oe && data_out == model, "R5 hold", data_out, model);
    end
    dack_in = 1'b1;
    @(negedge clk);
    chk(!data_oe && !data_stb && data_out == 16'd0, "R6 release",
        data_out, 16'd0);
    dack_in = 1'b0; addr_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_silent(input logic [7:0] s);
    @(negedge clk);
    src_sel = s; dst_sel = 8'($urandom); addr_stb = 1'b1;
    @(negedge clk);
    quiet("R7 silent socket");
    @(negedge clk);
    quiet("R7 silent socket");
    addr_stb = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(data_out == 16'd0, "R1 reset bus", data_out, 16'd0);
    quiet("R1 reset strobes");
    rst_n = 1'b1;
    @(negedge clk);
    do_read("R1 reset register", 0);

    do_load(1'b0, 8'h0E, 0);
    do_load(1'b1, 8'h0B, 0);
    do_read("R9 0x0B0E", 1);
    do_load(1'b0, 8'hA5, 0);
    do_read("R2 low merge", 0);
    do_load(1'b1, 8'h3C, 3);
    do_read("R3 high merge R8", 2);
    do_load(1'b1, 8'hFF, 0);
    do_load(1'b1, 8'h00, 0);
    do_read("R3 repeat high", 0);
    do_silent(BASE + 8'd3);
    do_silent(8'h00);
    do_read("R7 unchanged", 0);

    for (int n = 0; n < 200; n++) begin
      int op;
      logic [7:0] s;
      op = int'($urandom_range(0, 4));
      case (op)
        0: do_load(1'b0, 8'($urandom), int'($urandom_range(0, 2)));
        1: do_load(1'b1, 8'($urandom), int'($urandom_range(0, 2)));
        2: do_read("R2 R3 random read", int'($urandom_range(0, 3)));
        3: do_silent(BASE + 8'd3);
        default: begin
          s = 8'($urandom);
          if (s[7:2] == BASE[7:2]) s = s ^ 8'h80;
          do_silent(s);
        end
      endcase
    end
    do_read("R7 final", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule